// File: doc/BRIEF.md
# Return-Jump Branch Sequencer

This block resolves the control-flow part of a sequencer whose memory words are 60 bits wide and carry two 30-bit instruction parcels. It accepts one decoded operation at a time. An operation is either an equality branch on two 18-bit index values or a return-jump call. Along with the operation it takes the current word address, an 18-bit target and the two index values. It produces a redirect strobe with the next word address, a flush of any parcel left in the current word, and a memory write request.

A call does not push its return linkage onto a stack or save it in a link register. Instead it stores a ready-made jump instruction into the callee's entry word K. That word is an unconditional equality branch back to the caller's word address plus one. Execution then resumes at K+1. The callee returns by branching to K, which runs the stored jump. The write must be acknowledged before the redirect to K+1 is raised. While a write is outstanding, further operations are ignored.

Top module: `rjump_seq`

## Requirements
- R1: After reset, `redirect`, `flush` and `mem_wr_req` are low.
- R2: An accepted branch whose two index values are equal raises `redirect` and `flush` for one cycle on the next cycle, with `next_addr` equal to the target.
- R3: An accepted branch whose index values differ raises neither `redirect` nor `flush`.
- R4: A branch comparing zero with zero, which is the index-0-with-itself form, is always taken, so it acts as an unconditional jump.
- R5: An accepted call raises `mem_wr_req` on the next cycle. `mem_wr_addr` equals the target. `mem_wr_data[59:30]` holds opcode 6'o04 in bits 59:54, zero in the two 3-bit register fields at bits 53:48, and the return address in bits 47:30. `mem_wr_data[29:0]` holds the no-op pattern 30'o4600046000.
- R6: The return address is the current word address plus one, modulo 2^18.
- R7: While `mem_wr_req` waits for `mem_wr_ack`, the request, its address and its data stay stable, and `redirect` stays low.
- R8: The cycle after `mem_wr_ack` is sampled high with a pending request, `redirect` and `flush` are high for one cycle, `next_addr` equals target plus one modulo 2^18, and `mem_wr_req` is low.
- R9: An operation presented while a write is pending is ignored and causes no redirect.
- R10: `redirect` lasts a single cycle unless a new taken operation follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | A decoded operation is presented |
| op_is_call | input | 1 | 1 = return-jump call, 0 = equality branch |
| cur_addr | input | 18 | Word address of the current instruction word |
| op_target | input | 18 | Branch or call target word K |
| idx_a | input | 18 | First compared index value |
| idx_b | input | 18 | Second compared index value |
| mem_wr_ack | input | 1 | Memory accepts the pending write |
| redirect | output | 1 | One-cycle strobe: fetch continues at next_addr |
| next_addr | output | 18 | Word address to resume at |
| flush | output | 1 | Discard the remaining parcel of the current word |
| mem_wr_req | output | 1 | Write request for the return word |
| mem_wr_addr | output | 18 | Write address (callee entry word) |
| mem_wr_data | output | 60 | Generated return branch word |

## Verification
A branch result appears exactly one clock edge after the operation is sampled. The bench drives each operation on a falling edge and checks `redirect`, `flush` and `next_addr` on the following falling edge. A call's write request likewise appears one edge after the call is sampled. Its redirect appears one edge after the acknowledge is sampled, so the bench checks the write fields one falling edge after the call and the redirect one falling edge after raising the acknowledge. It then checks one edge later that the strobe has dropped. Acknowledge delays of zero to two cycles are swept, and ignored operations are injected during each wait.

// File: rtl/rjump_seq.sv
module rjump_seq #(
  parameter int AW = 18,
  parameter int WW = 60,
  parameter int OPW = 6,
  parameter int RW = 3,
  parameter logic [OPW-1:0] EQ_OPC = 6'o04,
  parameter logic [WW/2-1:0] NOP_PARCEL = 30'o4600046000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic          op_is_call,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] op_target,
  input  logic [AW-1:0] idx_a,
  input  logic [AW-1:0] idx_b,
  input  logic          mem_wr_ack,
  output logic          redirect,
  output logic [AW-1:0] next_addr,
  output logic          flush,
  output logic          mem_wr_req,
  output logic [AW-1:0] mem_wr_addr,
  output logic [WW-1:0] mem_wr_data
);
  localparam int PW = WW / 2;
  localparam logic [AW-1:0] ONE = AW'(1);
  localparam logic [RW-1:0] RZ = '0;

  logic          waiting;
  logic [AW-1:0] ret_addr;
  logic          taken;

  assign ret_addr   = cur_addr + ONE;
  assign taken      = idx_a == idx_b;
  assign mem_wr_req = waiting;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      waiting     <= 1'b0;
      redirect    <= 1'b0;
      flush       <= 1'b0;
      next_addr   <= '0;
      mem_wr_addr <= '0;
      mem_wr_data <= '0;
    end else begin
      redirect <= 1'b0;
      flush    <= 1'b0;
      if (waiting) begin
        if (mem_wr_ack) begin
          waiting   <= 1'b0;
          redirect  <= 1'b1;
          flush     <= 1'b1;
          next_addr <= mem_wr_addr + ONE;
        end
      end else if (op_valid) begin
        if (op_is_call) begin
          waiting     <= 1'b1;
          mem_wr_addr <= op_target;
          mem_wr_data <= {EQ_OPC, RZ, RZ, ret_addr, NOP_PARCEL};
        end else if (taken) begin
          redirect  <= 1'b1;
          flush     <= 1'b1;
          next_addr <= op_target;
        end
      end
    end
  end
endmodule

// File: rtl/rjump_seq_chk.sv
module rjump_seq_chk #(
  parameter int AW = 18,
  parameter int WW = 60,
  parameter int OPW = 6,
  parameter logic [OPW-1:0] EQ_OPC = 6'o04
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_valid,
  input logic          op_is_call,
  input logic [AW-1:0] idx_a,
  input logic [AW-1:0] idx_b,
  input logic          mem_wr_ack,
  input logic          redirect,
  input logic          flush,
  input logic          mem_wr_req,
  input logic [AW-1:0] mem_wr_addr,
  input logic [WW-1:0] mem_wr_data
);
  p_redirect_flush_r2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> flush);

  p_no_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_is_call && !mem_wr_req && (idx_a != idx_b) |=> !redirect && !flush);

  p_ret_opcode_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> mem_wr_data[WW-1 -: OPW] == EQ_OPC && mem_wr_data[WW-OPW-1 -: 6] == '0);

  p_req_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack |=> mem_wr_req && $stable(mem_wr_addr) && $stable(mem_wr_data));

  p_no_early_redirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req |-> !redirect);

  p_ack_redirect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && mem_wr_ack |=> redirect && flush && !mem_wr_req);

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_req && !mem_wr_ack && op_valid |=> !redirect);
endmodule

bind rjump_seq rjump_seq_chk #(.AW(AW), .WW(WW), .OPW(OPW), .EQ_OPC(EQ_OPC)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_call(op_is_call),
  .idx_a(idx_a), .idx_b(idx_b), .mem_wr_ack(mem_wr_ack), .redirect(redirect),
  .flush(flush), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
  .mem_wr_data(mem_wr_data)
);

// File: tb/rjump_seq_test.sv
module rjump_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0, op_is_call = 1'b0, mem_wr_ack = 1'b0;
  logic [17:0] cur_addr = '0, op_target = '0, idx_a = '0, idx_b = '0;
  logic        redirect, flush, mem_wr_req;
  logic [17:0] next_addr, mem_wr_addr;
  logic [59:0] mem_wr_data;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rjump_seq uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_is_call(op_is_call),
    .cur_addr(cur_addr), .op_target(op_target), .idx_a(idx_a), .idx_b(idx_b),
    .mem_wr_ack(mem_wr_ack), .redirect(redirect), .next_addr(next_addr),
    .flush(flush), .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_branch(input logic [17:0] a, input logic [17:0] b, input logic [17:0] t);
    logic tk;
    tk = (a == b);
    @(negedge clk);
    op_valid = 1; op_is_call = 0; idx_a = a; idx_b = b; op_target = t;
    @(negedge clk);
    op_valid = 0;
    if (a == 0 && b == 0) chk("R4 zero-zero taken", redirect, 1);
    else if (tk) chk("R2 equal taken", redirect, 1);
    else chk("R3 unequal not taken", redirect, 0);
    chk(tk ? "R2 flush" : "R3 no flush", flush, tk);
    if (tk) chk("R2 next_addr", next_addr, t);
    @(negedge clk);
    chk("R10 redirect single cycle", redirect, 0);
  endtask

  task automatic do_call(input logic [17:0] cur, input logic [17:0] t, input int d);
    logic [59:0] exp_w;
    logic [17:0] ret, nxt;
    ret = cur + 18'd1;
    nxt = t + 18'd1;
    exp_w = {6'o04, 3'd0, 3'd0, ret, 30'o4600046000};
    @(negedge clk);
    op_valid = 1; op_is_call = 1; cur_addr = cur; op_target = t;
    @(negedge clk);
    op_valid = 0;
    chk("R5 write request", mem_wr_req, 1);
    chk("R5 write address", mem_wr_addr, t);
    chk("R5 R6 return word", mem_wr_data, exp_w);
    chk("R7 no redirect before ack", redirect, 0);
    for (int i = 0; i < d; i++) begin
      op_valid = 1; op_is_call = (i % 2 == 1); idx_a = 18'd3; idx_b = 18'd3; op_target = 18'h155;
      @(negedge clk);
      op_valid = 0;
      chk("R9 ignored while busy", redirect, 0);
      chk("R7 request held", mem_wr_req, 1);
      chk("R7 data held", mem_wr_data, exp_w);
      chk("R7 address held", mem_wr_addr, t);
    end
    mem_wr_ack = 1;
    @(negedge clk);
    mem_wr_ack = 0;
    chk("R8 redirect after ack", redirect, 1);
    chk("R8 flush", flush, 1);
    chk("R8 next_addr target+1", next_addr, nxt);
    chk("R8 request dropped", mem_wr_req, 0);
    @(negedge clk);
    chk("R10 redirect single cycle", redirect, 0);
  endtask

  initial begin
    logic [17:0] vals [4];
    logic [17:0] addrs [3];
    vals = '{18'd0, 18'd1, 18'd5, 18'h3FFFF};
    addrs = '{18'd0, 18'd7, 18'h3FFFF};
    repeat (3) @(negedge clk);
    chk("R1 redirect reset", redirect, 0);
    chk("R1 flush reset", flush, 0);
    chk("R1 req reset", mem_wr_req, 0);
    rst_n = 1;
    for (int i = 0; i < 4; i++)
      for (int j = 0; j < 4; j++)
        do_branch(vals[i], vals[j], 18'(i * 40 + j * 3 + 1));
    for (int i = 0; i < 3; i++)
      for (int j = 0; j < 3; j++)
        for (int d = 0; d < 3; d++)
          do_call(addrs[i], addrs[j], d);
    do_branch(18'd0, 18'd0, 18'h3FFFF);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule